// File: doc/BRIEF.md
# Serial Memory Write-Permission Controller

This block decides whether a nonvolatile write in a serial-attached memory may go ahead. A command decoder upstream presents one-cycle strobes for set-enable, clear-enable, array write and status write, together with the target address and the new status byte. The controller holds a write-enable latch and a status register. The status register carries two block-protect bits and a pin-arming bit. The controller also samples a hardware write-protect pin, which is active low.

A write request is judged on the cycle its strobe arrives, and that verdict is held. The write is acted on only when chip-select goes high at the end of the frame. An allowed array write produces a grant pulse and its address for the storage logic. An allowed status write updates the register. Each commit starts a self-timed busy interval. Every attempted write clears the write-enable latch, whether it was allowed or not.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, busy is low and neither grant pulses.
- R2: After reset, every command is ignored until chip-select has been seen high and then low.
- R3: An array or status write strobed while the write-enable latch is clear is ignored. It gives no grant and no busy.
- R4: A permitted array write gives a one-cycle `arr_grant` with `grant_addr` equal to the strobed address. This happens on the cycle after chip-select rises.
- R5: Every attempted write clears the write-enable latch at chip-select rise. A granted write holds busy high for exactly `WRITE_CYC` cycles.
- R6: While busy is high, every command strobe is ignored.
- R7: The block-protect code selects the locked range. Code 0 locks nothing. Code 1 locks the top quarter of the address space. Code 2 locks the top half. Code 3 locks all of it. A write inside the locked range is dropped.
- R8: When the arming bit is 0, the write-protect pin has no effect, and status writes proceed with the pin low.
- R9: When the arming bit is 1 and the pin is low, status writes are refused, but array writes are still judged only by the locked range.
- R10: The verdict is taken at the strobe. The pin falling after the strobe, up to and including the commit cycle, does not stop that status write.
- R11: The clear-enable strobe clears the write-enable latch.
- R12: The status byte reads as follows: bit 7 is the arming bit, bits 3:2 are the protect code, bit 1 is the latch and bit 0 is busy. A status write loads only bits 7 and 3:2 of `sr_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select level, active low |
| wp_n | input | 1 | Write-protect pin level, active low |
| cmd_wren | input | 1 | Set-enable strobe |
| cmd_wrdi | input | 1 | Clear-enable strobe |
| cmd_write | input | 1 | Array write strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wr_addr | input | ADDR_W | Array write start address |
| sr_wdata | input | 8 | New status byte |
| arr_grant | output | 1 | One-cycle array write commit |
| sr_grant | output | 1 | One-cycle status write commit |
| grant_addr | output | ADDR_W | Address of the committed array write |
| busy | output | 1 | Self-timed write in progress |
| status | output | 8 | Status byte |

## Verification
The pin gate and the commit can fall in the same cycle. The bench strobes a status write while the pin is high, then lowers the pin on the very cycle chip-select rises. The scoreboard must still see the status grant, and the new byte must be readable. The following status write, made with the pin held low, must produce no grant and must leave the byte unchanged.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_ARR  = 2'd1,
        REQ_SR   = 2'd2
    } req_kind_e;

    localparam int unsigned ST_ARM  = 7;
    localparam int unsigned ST_BPHI = 3;
    localparam int unsigned ST_BPLO = 2;
    localparam int unsigned ST_WEL  = 1;
    localparam int unsigned ST_BSY  = 0;
endpackage

// File: rtl/wprot_range.sv
module wprot_range #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned TOP = ADDR_W - 1;

    logic quarter_hit;
    logic half_hit;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign quarter_hit = addr[TOP] & addr[TOP-1];
        end else begin : g_narrow
            assign quarter_hit = addr[TOP];
        end
    endgenerate

    assign half_hit = addr[TOP];

    always_comb begin
        unique case (bp)
            2'd0: hit = 1'b0;
            2'd1: hit = quarter_hit;
            2'd2: hit = half_hit;
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_busy.sv
module wprot_busy #(
    parameter int unsigned WRITE_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(WRITE_CYC + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CNT_W'(WRITE_CYC);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("busy did not rise"); // R5
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned WRITE_CYC = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_write,
    input  logic              cmd_wrsr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        sr_wdata,
    output logic              arr_grant,
    output logic              sr_grant,
    output logic [ADDR_W-1:0] grant_addr,
    output logic              busy,
    output logic [7:0]        status
);
    typedef struct packed {
        logic              cs;
        logic              armed;
        logic              wel;
        logic              wpen;
        logic [1:0]        bp;
        logic              pend_vld;
        req_kind_e         pend_kind;
        logic              pend_ok;
        logic [ADDR_W-1:0] pend_addr;
        logic              pend_wpen;
        logic [1:0]        pend_bp;
        logic              arr_grant;
        logic              sr_grant;
        logic [ADDR_W-1:0] grant_addr;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic prot_hit;
    logic commit_start;
    logic cs_fall;
    logic cs_rise;
    logic accept;
    logic pin_block;

    wprot_range #(.ADDR_W(ADDR_W)) u_range (
        .bp   (s_q.bp),
        .addr (wr_addr),
        .hit  (prot_hit)
    );

    wprot_busy #(.WRITE_CYC(WRITE_CYC)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_start),
        .busy  (busy)
    );

    always_comb begin
        s_d           = s_q;
        s_d.arr_grant = 1'b0;
        s_d.sr_grant  = 1'b0;
        s_d.cs        = cs_n;
        commit_start  = 1'b0;

        cs_fall   = s_q.cs & ~cs_n;
        cs_rise   = ~s_q.cs & cs_n;
        accept    = s_q.armed & ~cs_n & ~busy;
        pin_block = s_q.wpen & ~wp_n;

        if (cs_fall) begin
            s_d.armed = 1'b1;
        end

        if (accept) begin
            if (cmd_wren) s_d.wel = 1'b1;
            if (cmd_wrdi) s_d.wel = 1'b0;
            if (s_q.wel && cmd_write) begin
                s_d.pend_vld  = 1'b1;
                s_d.pend_kind = REQ_ARR;
                s_d.pend_ok   = ~prot_hit;
                s_d.pend_addr = wr_addr;
            end else if (s_q.wel && cmd_wrsr) begin
                s_d.pend_vld  = 1'b1;
                s_d.pend_kind = REQ_SR;
                s_d.pend_ok   = ~pin_block;
                s_d.pend_wpen = sr_wdata[ST_ARM];
                s_d.pend_bp   = sr_wdata[ST_BPHI:ST_BPLO];
            end
        end

        if (cs_rise) begin
            s_d.pend_vld  = 1'b0;
            s_d.pend_kind = REQ_NONE;
            if (s_q.pend_vld) begin
                s_d.wel = 1'b0;
                if (s_q.pend_ok) begin
                    commit_start = 1'b1;
                    if (s_q.pend_kind == REQ_ARR) begin
                        s_d.arr_grant  = 1'b1;
                        s_d.grant_addr = s_q.pend_addr;
                    end else begin
                        s_d.sr_grant = 1'b1;
                        s_d.wpen     = s_q.pend_wpen;
                        s_d.bp       = s_q.pend_bp;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign arr_grant  = s_q.arr_grant;
    assign sr_grant   = s_q.sr_grant;
    assign grant_addr = s_q.grant_addr;
    assign status     = {s_q.wpen, 3'b000, s_q.bp, s_q.wel, busy};

    AST_UNARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.armed |-> !s_q.wel) else $error("latch set before arming"); // R2
    AST_GRANT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant || sr_grant) |-> $past(s_q.wel)) else $error("grant without latch"); // R4
    AST_COMMIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_grant || sr_grant) |-> (!s_q.wel && busy)) else $error("latch kept or not busy"); // R5
    AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_grant |-> !$past(busy)) else $error("grant during busy"); // R6
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_grant && sr_grant)) else $error("two grants"); // R4
endmodule

// File: tb/wprot_ctrl_tb_top.sv
module wprot_ctrl_tb_top;
    localparam int unsigned AW  = 11;
    localparam int unsigned CYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic wp_n = 1'b1;
    logic cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_write = 1'b0, cmd_wrsr = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    sr_wdata = '0;
    logic arr_grant, sr_grant, busy;
    logic [AW-1:0] grant_addr;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;
    logic [AW:0] exp_q[$];

    always #4 clk = ~clk;

    wprot_ctrl #(.ADDR_W(AW), .WRITE_CYC(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_write(cmd_write), .cmd_wrsr(cmd_wrsr),
        .wr_addr(wr_addr), .sr_wdata(sr_wdata),
        .arr_grant(arr_grant), .sr_grant(sr_grant), .grant_addr(grant_addr),
        .busy(busy), .status(status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every grant must match the head of the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && (arr_grant || sr_grant)) begin
            logic [AW:0] got;
            got = sr_grant ? {1'b1, {AW{1'b0}}} : {1'b0, grant_addr};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 unexpected grant actual=%0h expected=none", got);
            end else begin
                logic [AW:0] want;
                want = exp_q.pop_front();
                if (got !== want) begin
                    errors++;
                    $display("FAIL R4 grant actual=%0h expected=%0h", got, want);
                end
            end
        end
    end

    // one framed command; kind 0 wren,1 wrdi,2 write,3 wrsr
    task automatic frame(input int kind, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit expect_grant, input bit drop_wp_at_end);
        @(negedge clk) cs_n = 1'b0;
        @(negedge clk);
        wr_addr  = a;
        sr_wdata = d;
        cmd_wren  = (kind == 0);
        cmd_wrdi  = (kind == 1);
        cmd_write = (kind == 2);
        cmd_wrsr  = (kind == 3);
        if (expect_grant) exp_q.push_back((kind == 3) ? {1'b1, {AW{1'b0}}} : {1'b0, a});
        @(negedge clk);
        cmd_wren = 0; cmd_wrdi = 0; cmd_write = 0; cmd_wrsr = 0;
        cs_n = 1'b1;
        if (drop_wp_at_end) wp_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic enable();
        frame(0, '0, 8'h00, 0, 0);
    endtask

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                chk("R1 status", status, 8'h00);
                chk("R1 busy", busy, 0);
                // R2: cs held low since reset, no falling edge yet
                cmd_wren = 1'b1;
                @(negedge clk) cmd_wren = 1'b0;
                @(negedge clk);
                chk("R2 latch before arming", status[1], 0);
                cs_n = 1'b1;
                @(negedge clk);
                // R3 write without latch
                frame(2, 11'h010, 0, 0, 0);
                chk("R3 no busy", busy, 0);
                frame(3, 0, 8'h8C, 0, 0);
                chk("R3 status kept", status, 8'h00);
                // R4/R5 allowed write and busy length
                enable();
                chk("R12 latch bit", status, 8'h02);
                frame(2, 11'h123, 0, 1, 0);
                begin
                    int n = 0;
                    chk("R5 latch cleared", status[1], 0);
                    while (busy) begin n++; @(negedge clk); end
                    chk("R5 busy length", n, CYC);
                end
                // R6 commands ignored while busy
                enable();
                frame(2, 11'h050, 0, 1, 0);
                frame(0, 0, 0, 0, 0);
                chk("R6 latch ignored while busy", status[1], 0);
                wait_idle();
                // R11 clear-enable
                enable();
                frame(1, 0, 0, 0, 0);
                chk("R11 latch cleared", status[1], 0);
                // R12 status write loads bits 7 and 3:2 only, code 1
                enable();
                frame(3, 0, 8'h77, 1, 0);
                chk("R12 status bp=1", status, 8'h05);
                wait_idle();
                // R7 quarter
                enable();
                frame(2, 11'h700, 0, 0, 0);
                chk("R7 quarter dropped, latch clear", status, 8'h04);
                enable();
                frame(2, 11'h5FF, 0, 1, 0);
                wait_idle();
                // R7 half
                enable(); frame(3, 0, 8'h08, 1, 0); wait_idle();
                enable(); frame(2, 11'h400, 0, 0, 0);
                chk("R7 half dropped busy", busy, 0);
                enable(); frame(2, 11'h3FF, 0, 1, 0); wait_idle();
                // R7 all
                enable(); frame(3, 0, 8'h0C, 1, 0); wait_idle();
                enable(); frame(2, 11'h000, 0, 0, 0);
                chk("R7 all dropped", busy, 0);
                // R8 pin ignored while arming bit 0
                wp_n = 1'b0;
                enable(); frame(3, 0, 8'h80, 1, 0);
                chk("R8 status written with pin low", status, 8'h81);
                wait_idle();
                // R9 refused with pin low and arming bit 1
                enable(); frame(3, 0, 8'h00, 0, 0);
                chk("R9 status kept", status, 8'h80);
                enable(); frame(2, 11'h7FF, 0, 1, 0);
                chk("R9 array still allowed", busy, 1);
                wait_idle();
                // R10 pin drops on the commit cycle
                wp_n = 1'b1;
                enable(); frame(3, 0, 8'h84, 1, 1);
                chk("R10 write not aborted", status, 8'h85);
                wait_idle();
                enable(); frame(3, 0, 8'h88, 0, 0);
                chk("R10 later attempt blocked", status, 8'h84);
                repeat (3) @(negedge clk);
                chk("R4 scoreboard drained", exp_q.size(), 0);
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule